// File: doc/BRIEF.md
# Buffered Auto-Reload Timer Channel Bank

This block holds five down-counting timer channels that share one control word. Each channel keeps a count buffer that software writes and a live counter that counts down. The first four channels also keep a compare buffer, which is stored and read back but drives no logic here. Software reaches everything through a simple register-write port and a combinational read port. A separate prescaler supplies one tick-enable per channel.

The live counter is never written directly. It takes the buffer value only when the channel's update bit in the control word goes from 0 to 1. A channel runs while its start bit is set and moves one step per tick. The tick on which it sits at zero is its expiry, marked by a one-cycle pulse. After expiry the channel either reloads from its buffer and keeps going, or it stops and clears its own start bit. Start and stop follow edges of the start bit. The last channel has a shifted control layout with no invert bit and no compare buffer.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads 0: the control word, all count and compare buffers and all live counts. No expiry pulse is asserted.
- R2: Control word at byte address 0x08. For channel n in 0..3, base bit b is 0 when n=0 and 4n+4 otherwise. Bit b is start, b+1 is update, b+2 is invert (stored only) and b+3 is auto-reload. Channel 4 uses start bit 20, update bit 21 and auto-reload bit 22. The control word reads back as written, apart from start bits cleared by R9.
- R3: Channel n has its count buffer at 0x0C+0xC*n. For n<4 its compare buffer is at 0x10+0xC*n and its live count at 0x14+0xC*n. Channel 4's live count is at 0x40. Buffers read back what was written. Writes to live-count addresses are ignored, and reads of unmapped addresses (0x00, 0x04, 0x44..0x4C) return 0.
- R4: A control write that takes a channel's update bit from 0 to 1 copies its count buffer into its live counter on that clock edge. A write that leaves the update bit at 1 does not reload.
- R5: A 0-to-1 change of the start bit starts the channel and a 1-to-0 change stops it. A write that leaves the start bit unchanged leaves the run state unchanged. A stopped channel ignores ticks.
- R6: A running channel with a nonzero count decrements by one on each clock edge where its tick enable is high, and holds otherwise.
- R7: A tick on a running channel whose count is 0 is an expiry. The channel's expire output is high for exactly the one cycle after that edge.
- R8: On expiry with auto-reload set, the counter takes the count buffer value and keeps running, so the expiry period is buffer+1 ticks.
- R9: On expiry with auto-reload clear, the counter stays at 0, the channel stops, and its start bit reads back 0.
- R10: If one control write raises both the update and the start bit of a channel, the load happens first and counting proceeds from the loaded value.
- R11: On a clock edge where the control word is written, no channel counts, even with its tick enable high.
- R12: Reading a live-count register does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 5 | Per-channel count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| expire | output | 5 | One-cycle expiry pulse per channel |

## Verification
The hardest case to reach is the moment a channel's counter sits at zero while it is running, and the clock edge that follows decides its fate. Reaching it needs a loaded buffer, an update edge and a start edge in the right order. The exact number of ticks must follow, and the auto-reload bit must sit at the channel's own position, which for the last channel is shifted. The bench gets there by loading and starting each channel in a single control write. It then steps the prescaler enables one cycle at a time for a computed number of ticks, sweeping every channel over buffer values of 0, 1 and a channel-dependent larger value. It then repeats the approach with auto-reload clear, to observe the hardware-cleared start bit.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
    localparam int NUM_CH   = 5;
    localparam int CTL_ADDR = 8;

    function automatic int base_bit(input int n);
        return (n == 0) ? 0 : 4 * n + 4;
    endfunction

    function automatic int start_bit(input int n);
        return base_bit(n);
    endfunction

    function automatic int upd_bit(input int n);
        return base_bit(n) + 1;
    endfunction

    // last channel has no invert bit, so its reload bit moves down by one
    function automatic int reload_bit(input int n);
        return (n == NUM_CH - 1) ? base_bit(n) + 2 : base_bit(n) + 3;
    endfunction

    function automatic int cntb_addr(input int n);
        return 12 + 12 * n;
    endfunction

    function automatic int cmpb_addr(input int n);
        return 16 + 12 * n;
    endfunction

    function automatic int live_addr(input int n);
        return (n == NUM_CH - 1) ? 64 : 20 + 12 * n;
    endfunction
endpackage

// File: rtl/timer_chan.sv
module timer_chan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              reload_i,
    input  logic [DATA_W-1:0] buf_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o,
    output logic              halt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              expire;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        halt_o      = 1'b0;
        if (load_i) begin
            st_d.cnt = buf_i;
        end else if (step_i) begin
            if (st_q.cnt == '0) begin
                st_d.expire = 1'b1;
                if (reload_i) st_d.cnt = buf_i;
                else          halt_o   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign expire_o = st_q.expire;

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(buf_i)));

    assert_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1) && !expire_o);

    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cnt_o == '0 && reload_i) |=> (cnt_o == $past(buf_i)) && expire_o);

    assert_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cnt_o == '0 && !reload_i) |=> (cnt_o == '0) && expire_o);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(cnt_o) && !expire_o);
endmodule

// File: rtl/timer_rd_mux.sv
module timer_rd_mux
    import timer_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DATA_W-1:0]                ctl_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]    cntb_i,
    input  logic [NUM_CH-2:0][DATA_W-1:0]    cmpb_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]    live_i,
    output logic [DATA_W-1:0]                data_o
);
    always_comb begin
        data_o = '0;
        if (addr_i == ADDR_W'(CTL_ADDR)) data_o = ctl_i;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr_i == ADDR_W'(cntb_addr(n))) data_o = cntb_i[n];
            if (addr_i == ADDR_W'(live_addr(n))) data_o = live_i[n];
            if (n < NUM_CH - 1 && addr_i == ADDR_W'(cmpb_addr(n)))
                data_o = cmpb_i[n];
        end
    end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import timer_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [4:0]        expire
);
    typedef struct packed {
        logic [DATA_W-1:0]                 ctl;
        logic [NUM_CH-1:0][DATA_W-1:0]     cntb;
        logic [NUM_CH-2:0][DATA_W-1:0]     cmpb;
    } regs_t;

    regs_t rg_d, rg_q;

    logic                           ctl_wr;
    logic [NUM_CH-1:0]              upd_rise, start_rise, step, halt;
    logic [NUM_CH-1:0][DATA_W-1:0]  live;

    assign ctl_wr = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int SB = start_bit(n);
        localparam int UB = upd_bit(n);
        localparam int AB = reload_bit(n);

        assign upd_rise[n]   = ctl_wr && wr_data[UB] && !rg_q.ctl[UB];
        assign start_rise[n] = ctl_wr && wr_data[SB] && !rg_q.ctl[SB];
        assign step[n]       = rg_q.ctl[SB] && tick_en[n] && !ctl_wr;

        timer_chan #(.DATA_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (upd_rise[n]),
            .step_i   (step[n]),
            .reload_i (rg_q.ctl[AB]),
            .buf_i    (rg_q.cntb[n]),
            .cnt_o    (live[n]),
            .expire_o (expire[n]),
            .halt_o   (halt[n])
        );

        assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
            start_rise[n] |=> rg_q.ctl[SB]);

        assert_selfstop_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (halt[n] && !ctl_wr) |=> !rg_q.ctl[SB]);

        assert_ctlfreeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && !upd_rise[n]) |=> $stable(live[n]));
    end

    always_comb begin
        rg_d = rg_q;
        if (ctl_wr) rg_d.ctl = wr_data;
        for (int n = 0; n < NUM_CH; n++) begin
            if (wr_en && wr_addr == ADDR_W'(cntb_addr(n))) rg_d.cntb[n] = wr_data;
            if (n < NUM_CH - 1 && wr_en && wr_addr == ADDR_W'(cmpb_addr(n)))
                rg_d.cmpb[n] = wr_data;
            if (halt[n]) rg_d.ctl[start_bit(n)] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    timer_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .addr_i (rd_addr),
        .ctl_i  (rg_q.ctl),
        .cntb_i (rg_q.cntb),
        .cmpb_i (rg_q.cmpb),
        .live_i (live),
        .data_o (rd_data)
    );

    assert_expire_onestep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |-> $past(tick_en != '0));
endmodule

// File: tb/tb_timer_bank.sv
`timescale 1ns/1ps
module tb_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick_en = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [4:0]  expire;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    timer_bank dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .expire(expire)
    );

    function automatic int sbit(int n); return (n == 0) ? 0 : 4 * n + 4; endfunction
    function automatic int ubit(int n); return sbit(n) + 1; endfunction
    function automatic int abit(int n); return (n == 4) ? 22 : sbit(n) + 3; endfunction
    function automatic int a_cntb(int n); return 12 + 12 * n; endfunction
    function automatic int a_cmpb(int n); return 16 + 12 * n; endfunction
    function automatic int a_live(int n); return (n == 4) ? 64 : 20 + 12 * n; endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(int a, logic [31:0] d, logic [4:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = d; tick_en = m;
        @(negedge clk);
        wr_en = 1'b0; tick_en = '0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        rd_addr = 7'(a);
        #1;
        d = rd_data;
    endtask

    task automatic tick(logic [4:0] m);
        @(negedge clk);
        tick_en = m;
        @(negedge clk);
        tick_en = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] b;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R3 unmapped reads
        for (int a = 0; a <= 76; a += 4) begin
            rd(a, d);
            check("R1 reset read", d, 0);
        end
        check("R1 no expire", 32'(expire), 0);

        for (int n = 0; n < 5; n++) begin
            // R3 buffers and ignored live writes
            rd(a_live(n), d);
            check("R3 live before load", d, 0);
            wr(a_live(n), 32'hDEAD_BEEF);
            rd(a_live(n), d);
            check("R3 live write ignored", d, 0);
            if (n < 4) begin
                wr(a_cmpb(n), 32'h55AA_0000 | 32'(n));
                rd(a_cmpb(n), d);
                check("R3 compare buffer", d, 32'h55AA_0000 | 32'(n));
            end

            // R8 R10 auto-reload sweep
            for (int k = 0; k < 3; k++) begin
                b = (k == 0) ? 0 : (k == 1) ? 1 : 32'(5 + n);
                wr(8, 0);
                wr(a_cntb(n), b);
                rd(a_cntb(n), d);
                check("R3 count buffer", d, b);
                w = (32'd1 << ubit(n)) | (32'd1 << sbit(n)) | (32'd1 << abit(n));
                wr(8, w);
                rd(8, d);
                check("R2 control readback", d, w);
                rd(a_live(n), d);
                check("R10 loaded before count", d, b);
                for (int t = 0; t < int'(b); t++) begin
                    tick(5'h1f);
                    check("R7 no early expire", 32'(expire), 0);
                    rd(a_live(n), d);
                    check("R6 decrement", d, b - 1 - 32'(t));
                end
                tick(5'h1f);
                check("R7 expire pulse", 32'(expire), 32'd1 << n);
                rd(a_live(n), d);
                check("R8 reload value", d, b);
                @(negedge clk);
                check("R7 pulse one cycle", 32'(expire), 0);
                rd(8, d);
                check("R8 still running", d, w);
            end

            // R9 one-shot
            wr(8, 0);
            wr(a_cntb(n), 2);
            w = (32'd1 << ubit(n)) | (32'd1 << sbit(n));
            wr(8, w);
            tick(5'h1f);
            tick(5'h1f);
            tick(5'h1f);
            check("R9 expire", 32'(expire), 32'd1 << n);
            rd(a_live(n), d);
            check("R9 count zero", d, 0);
            rd(8, d);
            check("R9 start bit cleared", d, 32'd1 << ubit(n));
            tick(5'h1f);
            check("R9 no further expire", 32'(expire), 0);
            rd(a_live(n), d);
            check("R9 stays zero", d, 0);

            // R4 R5 R11 R12
            wr(8, 0);
            wr(a_cntb(n), 9);
            wr(8, 32'd1 << ubit(n));
            tick(5'h1f);
            rd(a_live(n), d);
            check("R5 stopped ignores tick", d, 9);
            w = (32'd1 << ubit(n)) | (32'd1 << sbit(n));
            wr(8, w);
            tick(5'h1f);
            rd(a_live(n), d);
            check("R5 start edge runs", d, 8);
            wr(8, w);
            tick(5'h1f);
            rd(a_live(n), d);
            check("R5 no transition keeps running", d, 7);
            wr_tick(8, w, 5'h1f);
            rd(a_live(n), d);
            check("R11 control write freezes count", d, 7);
            wr(8, 32'd1 << ubit(n));
            tick(5'h1f);
            rd(a_live(n), d);
            check("R5 stop edge halts", d, 7);
            wr(a_cntb(n), 20);
            wr(8, 32'd1 << ubit(n));
            rd(a_live(n), d);
            check("R4 held update no reload", d, 7);
            wr(8, 0);
            wr(8, 32'd1 << ubit(n));
            rd(a_live(n), d);
            check("R4 update edge reloads", d, 20);
            for (int r = 0; r < 3; r++) begin
                @(negedge clk);
                rd(a_live(n), d);
                check("R12 read does not disturb", d, 20);
            end
            wr(8, 0);
            for (int m = 0; m < n; m++) begin
                rd(a_live(m), d);
                check("R6 other channels hold", d, 20);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule